// File: doc/BRIEF.md
# Capture/Compare Counter Array

This peripheral keeps one free-running 16-bit time base and hangs five independent channels off it. Each channel owns a 16-bit value register and is placed by software in one of several modes. It can stay idle. It can latch the count when its input pin changes, or raise a flag when the count reaches its value. It can flip its output pin on every such match, or drive a pulse-width modulated output from the low byte of the count. The last channel alone can also act as a watchdog: it fires a one-clock reset pulse unless software keeps moving its value ahead of the count.

Software reaches the block through a flat synchronous register port (address, write data, write strobe, read strobe, registered read data). Events from every channel and from time-base wrap-around land in sticky flags. The flags are cleared by writing ones, and any enabled flag raises the interrupt line. The time base advances once every `DIV` system clocks (two by default, about 166 ns per count at 12 MHz).

Top module: `capcmp_array`

## Requirements
- R1: With bit 0 of the control register (address 0) set, the count at address 1 rises by one every `DIV` clocks; with it clear the count holds; a write to address 1 loads the count.
- R2: When the count wraps from 0xFFFF to 0x0000, flag bit 5 of the flag register (address 2) is set.
- R3: In mode 1 (mode field bits [2:0] of channel i's mode register at address 4+i), edge field bits [4:3] pick the capture edge (01 rising, 10 falling, 11 either, 00 none). A chosen edge on the synchronized input latches the count into the channel value register (address 9+i) and sets flag bit i. Other edges leave both untouched.
- R4: In mode 2, a count equal to the channel value sets flag bit i while the channel output stays low.
- R5: In mode 3, the channel output inverts on each count match and sets flag bit i.
- R6: In mode 4, the channel output is low while the count's low byte is below the active duty byte and high otherwise. The active duty byte, which resets to 0, takes the value register's low byte only when the low byte of the count wraps to 0.
- R7: In mode 5, channel 4 pulses `wdt_rst` high for exactly one clock when the count equals its value, and sets no flag. Mode 5 on any other channel has no effect on outputs, flags or `wdt_rst`.
- R8: Flags stay set until a write to address 2 with a one in that bit; writing zeros leaves them alone.
- R9: `irq` is high exactly when some flag is set whose bit is set in the enable register (address 3, bits [5:0]).
- R10: After reset every register reads zero; a read strobe returns the addressed register on `bus_rdata` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| cap_in | input | 5 | Per-channel capture inputs |
| cmp_out | output | 5 | Per-channel toggle/PWM outputs |
| irq | output | 1 | Combined interrupt request |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
Capture is driven with rising, falling and either-edge selections, first on a running count and then on a frozen count. A frozen count shows which stored value came from which edge, and a rejected edge shows up as an unchanged value register. Compare modes run the count past the value twice (toggle) or once (software timer) to separate toggling from level-holding. PWM is probed at duty values on both sides of the threshold, before and after a low-byte wrap, which tells deferred duty loading apart from immediate loading. The watchdog is run both with regular rewrites and without them, and mode 5 is also placed on a channel other than 4, which separates a real timeout from a setting that must be ignored.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE   = 3'd0,
    MODE_CAPT   = 3'd1,
    MODE_SWT    = 3'd2,
    MODE_TOGGLE = 3'd3,
    MODE_PWM    = 3'd4,
    MODE_WDOG   = 3'd5
  } cc_mode_e;

  // Output level of a PWM channel for a given phase and duty byte.
  function automatic logic pwm_level(input logic [7:0] phase, input logic [7:0] duty);
    return !(phase < duty);
  endfunction

  // Edge qualifier: sel[0] accepts rising, sel[1] accepts falling.
  function automatic logic edge_hit(input logic [1:0] sel, input logic now_v, input logic prev_v);
    logic rise_v, fall_v;
    rise_v = now_v & ~prev_v;
    fall_v = ~now_v & prev_v;
    return (sel[0] & rise_v) | (sel[1] & fall_v);
  endfunction

endpackage

// File: rtl/capcmp_sync_edge.sv
module capcmp_sync_edge
  import capcmp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       hit
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  always_comb hit = edge_hit(sel, sync_q[STAGES-1], prev_q);

endmodule

// File: rtl/capcmp_timebase.sv
module capcmp_timebase #(
  parameter int CNT_W = 16,
  parameter int DIV   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic             wrap,
  output logic             lo_wrap
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;
  logic          adv;

  always_comb begin
    adv     = run && (pre_q == PW'(DIV - 1));
    wrap    = adv && !wr && (&cnt);
    lo_wrap = adv && !wr && (&cnt[7:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt   <= '0;
      step  <= 1'b0;
    end else begin
      if (!run || adv) pre_q <= '0;
      else             pre_q <= pre_q + 1'b1;
      if (wr)       cnt <= wdata;
      else if (adv) cnt <= cnt + 1'b1;
      step <= adv && !wr;
    end
  end

endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
  import capcmp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit WDOG_OK = 1'b0,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             step,
  input  logic             lo_wrap,
  input  logic             cap_in,
  input  logic             cfg_we,
  input  logic             val_we,
  input  logic [4:0]       cfg_data,
  input  logic [CNT_W-1:0] val_data,
  output logic [CNT_W-1:0] val,
  output logic [2:0]       mode,
  output logic [1:0]       esel,
  output logic             cap_evt,
  output logic             cmp_evt,
  output logic             wdt_hit,
  output logic             out
);

  cc_mode_e         mode_q;
  logic [1:0]       esel_q;
  logic [CNT_W-1:0] val_q;
  logic             tog_q;
  logic [7:0]       duty_q;
  logic             match;
  logic [1:0]       live_sel;

  capcmp_sync_edge #(.STAGES(SYNC_N)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_in),
    .sel  (live_sel),
    .hit  (cap_evt)
  );

  always_comb begin
    match    = step && (cnt == val_q);
    live_sel = (mode_q == MODE_CAPT) ? esel_q : 2'b00;
    cmp_evt  = match && ((mode_q == MODE_SWT) || (mode_q == MODE_TOGGLE));
    wdt_hit  = match && WDOG_OK && (mode_q == MODE_WDOG);
    case (mode_q)
      MODE_TOGGLE: out = tog_q;
      MODE_PWM:    out = pwm_level(cnt[7:0], duty_q);
      default:     out = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      esel_q <= 2'b00;
      val_q  <= '0;
      tog_q  <= 1'b0;
      duty_q <= 8'h00;
    end else begin
      if (cfg_we) begin
        mode_q <= cc_mode_e'(cfg_data[2:0]);
        esel_q <= cfg_data[4:3];
      end
      if (val_we)       val_q <= val_data;
      else if (cap_evt) val_q <= cnt;
      if (cfg_we)                                   tog_q <= 1'b0;
      else if (cmp_evt && mode_q == MODE_TOGGLE)    tog_q <= ~tog_q;
      if (lo_wrap) duty_q <= val_q[7:0];
    end
  end

  assign val  = val_q;
  assign mode = mode_q;
  assign esel = esel_q;

endmodule

// File: rtl/capcmp_array.sv
module capcmp_array #(
  parameter int CNT_W    = 16,
  parameter int NUM_MOD  = 5,
  parameter int WDOG_IDX = 4,
  parameter int DIV      = 2,
  parameter int AW       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic [CNT_W-1:0]   bus_wdata,
  input  logic               bus_we,
  input  logic               bus_re,
  output logic [CNT_W-1:0]   bus_rdata,
  input  logic [NUM_MOD-1:0] cap_in,
  output logic [NUM_MOD-1:0] cmp_out,
  output logic               irq,
  output logic               wdt_rst
);

  localparam int A_CTRL = 0;
  localparam int A_CNT  = 1;
  localparam int A_FLAG = 2;
  localparam int A_IEN  = 3;
  localparam int A_MODE = 4;
  localparam int A_VAL  = A_MODE + NUM_MOD;
  localparam int NF     = NUM_MOD + 1;

  logic             run_q;
  logic [NF-1:0]    ien_q;
  logic [NF-1:0]    flag_q;
  logic [NF-1:0]    flag_set;
  logic [NF-1:0]    flag_clr;
  logic             wdt_q;
  logic [CNT_W-1:0] rd_mux;
  logic [CNT_W-1:0] rdata_q;

  // Named internal events
  logic [CNT_W-1:0]   cnt_q;
  logic               cnt_wr;
  logic               step;
  logic               wrap_evt;
  logic               lo_wrap;
  logic [NUM_MOD-1:0] cap_evt;
  logic [NUM_MOD-1:0] cmp_evt;
  logic [NUM_MOD-1:0] hit_v;
  logic               wdt_hit;

  logic [CNT_W-1:0] u_val  [NUM_MOD];
  logic [2:0]       u_mode [NUM_MOD];
  logic [1:0]       u_esel [NUM_MOD];

  assign cnt_wr = bus_we && (bus_addr == AW'(A_CNT));

  capcmp_timebase #(.CNT_W(CNT_W), .DIV(DIV)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .wr     (cnt_wr),
    .wdata  (bus_wdata),
    .cnt    (cnt_q),
    .step   (step),
    .wrap   (wrap_evt),
    .lo_wrap(lo_wrap)
  );

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_unit
    logic cfg_we_i;
    logic val_we_i;
    assign cfg_we_i = bus_we && (bus_addr == AW'(A_MODE + i));
    assign val_we_i = bus_we && (bus_addr == AW'(A_VAL + i));

    capcmp_unit #(.CNT_W(CNT_W), .WDOG_OK(i == WDOG_IDX), .SYNC_N(2)) u_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt_q),
      .step    (step),
      .lo_wrap (lo_wrap),
      .cap_in  (cap_in[i]),
      .cfg_we  (cfg_we_i),
      .val_we  (val_we_i),
      .cfg_data(bus_wdata[4:0]),
      .val_data(bus_wdata),
      .val     (u_val[i]),
      .mode    (u_mode[i]),
      .esel    (u_esel[i]),
      .cap_evt (cap_evt[i]),
      .cmp_evt (cmp_evt[i]),
      .wdt_hit (hit_v[i]),
      .out     (cmp_out[i])
    );
  end

  always_comb begin
    wdt_hit  = |hit_v;
    flag_set = {wrap_evt, cap_evt | cmp_evt};
    flag_clr = (bus_we && bus_addr == AW'(A_FLAG)) ? bus_wdata[NF-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ien_q   <= '0;
      flag_q  <= '0;
      wdt_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (bus_we && bus_addr == AW'(A_CTRL)) run_q <= bus_wdata[0];
      if (bus_we && bus_addr == AW'(A_IEN))  ien_q <= bus_wdata[NF-1:0];
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      wdt_q  <= wdt_hit;
      if (bus_re) rdata_q <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(A_CTRL)) rd_mux[0] = run_q;
    if (bus_addr == AW'(A_CNT))  rd_mux = cnt_q;
    if (bus_addr == AW'(A_FLAG)) rd_mux[NF-1:0] = flag_q;
    if (bus_addr == AW'(A_IEN))  rd_mux[NF-1:0] = ien_q;
    for (int k = 0; k < NUM_MOD; k++) begin
      if (bus_addr == AW'(A_MODE + k)) rd_mux = {{(CNT_W-5){1'b0}}, u_esel[k], u_mode[k]};
      if (bus_addr == AW'(A_VAL + k))  rd_mux = u_val[k];
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = |(flag_q & ien_q);
  assign wdt_rst   = wdt_q;

endmodule

// File: rtl/capcmp_array_chk.sv
module capcmp_array_chk #(
  parameter int CNT_W   = 16,
  parameter int NUM_MOD = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   cnt,
  input logic               cnt_wr,
  input logic               step,
  input logic [NUM_MOD:0]   flag_q,
  input logic [NUM_MOD:0]   flag_clr,
  input logic [NUM_MOD-1:0] cap_evt,
  input logic               wdt_hit,
  input logic               wdt_rst
);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cnt == CNT_W'($past(cnt) + 1'b1));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !$past(cnt_wr)) |-> $stable(cnt));

  // R2
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[NUM_MOD]) |-> cnt == '0);

  // R3
  cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_evt) |=> ((flag_q[NUM_MOD-1:0] & $past(cap_evt)) == $past(cap_evt)));

  // R7
  wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  // R7
  wdt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(wdt_hit));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) & ~$past(flag_clr) & ~flag_q) == '0);

endmodule

bind capcmp_array capcmp_array_chk #(.CNT_W(CNT_W), .NUM_MOD(NUM_MOD)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt     (cnt_q),
  .cnt_wr  (cnt_wr),
  .step    (step),
  .flag_q  (flag_q),
  .flag_clr(flag_clr),
  .cap_evt (cap_evt),
  .wdt_hit (wdt_hit),
  .wdt_rst (wdt_rst)
);

// File: tb/capcmp_array_bench.sv
module capcmp_array_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic [4:0]  cap_in = '0;
  logic [4:0]  cmp_out;
  logic        irq;
  logic        wdt_rst;

  int n_chk = 0;
  int n_bad = 0;
  int wdt_seen = 0;

  always #10 clk = ~clk;

  capcmp_array u_capcmp_array (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq), .wdt_rst(wdt_rst)
  );

  always @(negedge clk) if (wdt_rst) wdt_seen++;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;
  localparam int NV = 20;
  // {req, op, addr, data, expected}
  localparam logic [41:0] VEC [NV] = '{
    {4'd10, OP_RD,   4'd0,  16'h0000, 16'h0000}, // R10 control
    {4'd10, OP_RD,   4'd1,  16'h0000, 16'h0000}, // R10 count
    {4'd8,  OP_RD,   4'd2,  16'h0000, 16'h0000}, // R8 flags
    {4'd9,  OP_RD,   4'd3,  16'h0000, 16'h0000}, // R9 enables
    {4'd10, OP_RD,   4'd4,  16'h0000, 16'h0000}, // R10 mode 0
    {4'd10, OP_RD,   4'd13, 16'h0000, 16'h0000}, // R10 value 4
    {4'd10, OP_WR,   4'd9,  16'h1234, 16'h0000},
    {4'd10, OP_RD,   4'd9,  16'h0000, 16'h1234}, // R10 value 0 readback
    {4'd3,  OP_WR,   4'd5,  16'h001B, 16'h0000},
    {4'd3,  OP_RD,   4'd5,  16'h0000, 16'h001B}, // R3 mode/edge fields
    {4'd9,  OP_WR,   4'd3,  16'hFFFF, 16'h0000},
    {4'd9,  OP_RD,   4'd3,  16'h0000, 16'h003F}, // R9 enable width
    {4'd1,  OP_WR,   4'd1,  16'h00F0, 16'h0000},
    {4'd1,  OP_IDLE, 4'd0,  16'd10,   16'h0000},
    {4'd1,  OP_RD,   4'd1,  16'h0000, 16'h00F0}, // R1 holds while stopped
    {4'd1,  OP_WR,   4'd0,  16'h0001, 16'h0000},
    {4'd1,  OP_IDLE, 4'd0,  16'd20,   16'h0000},
    {4'd1,  OP_RD,   4'd1,  16'h0000, 16'h00FA}, // R1 one step per two clocks
    {4'd1,  OP_WR,   4'd0,  16'h0000, 16'h0000},
    {4'd1,  OP_RD,   4'd1,  16'h0000, 16'h00FB}  // R1 stop
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    cap_in = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int base;
    @(negedge clk);
    do_reset();
    check("R10 bus_rdata after reset", bus_rdata, 16'h0000);
    check("R9 irq after reset", {15'b0, irq}, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] req; logic [1:0] op; logic [3:0] a; logic [15:0] d, e;
      {req, op, a, d, e} = VEC[v];
      if (op == OP_WR) wr(a, d);
      else if (op == OP_IDLE) idle(int'(d));
      else begin
        rd(a, r);
        check($sformatf("R%0d vector %0d", req, v), r, e);
      end
    end

    // R2 wrap flag and R9 interrupt
    do_reset();
    wr(4'd1, 16'hFFFE); wr(4'd3, 16'h0020); wr(4'd0, 16'h0001);
    idle(10);
    rd(4'd2, r); check("R2 wrap flag", r, 16'h0020);
    check("R9 irq with enabled flag", {15'b0, irq}, 16'h0001);
    wr(4'd2, 16'h0020);
    rd(4'd2, r); check("R8 clear by one", r, 16'h0000);
    check("R9 irq after clear", {15'b0, irq}, 16'h0000);

    // R4 software timer
    do_reset();
    wr(4'd6, 16'h0002); wr(4'd11, 16'h0010); wr(4'd0, 16'h0001);
    idle(40);
    rd(4'd2, r); check("R4 timer flag", r, 16'h0004);
    check("R4 output low", {15'b0, cmp_out[2]}, 16'h0000);
    check("R9 no irq when disabled", {15'b0, irq}, 16'h0000);
    wr(4'd2, 16'h0001);
    rd(4'd2, r); check("R8 zero bits keep flag", r, 16'h0004);

    // R5 toggle
    do_reset();
    wr(4'd4, 16'h0003); wr(4'd9, 16'h0005);
    check("R5 toggle initial", {15'b0, cmp_out[0]}, 16'h0000);
    wr(4'd0, 16'h0001);
    idle(40);
    check("R5 first match", {15'b0, cmp_out[0]}, 16'h0001);
    wr(4'd1, 16'h0000);
    idle(40);
    check("R5 second match", {15'b0, cmp_out[0]}, 16'h0000);
    rd(4'd2, r); check("R5 flag", r, 16'h0001);

    // R3 capture on a running count
    do_reset();
    wr(4'd1, 16'h0100); wr(4'd7, 16'h0009); wr(4'd0, 16'h0001);
    idle(10);
    cap_in[3] = 1'b1;
    idle(10);
    rd(4'd12, r); check("R3 rising capture value", r, 16'h0106);
    rd(4'd2, r);  check("R3 capture flag", r, 16'h0008);
    wr(4'd0, 16'h0000); wr(4'd2, 16'h003F);
    wr(4'd1, 16'h0555);
    cap_in[3] = 1'b0;
    idle(6);
    rd(4'd12, r); check("R3 falling ignored on rising select", r, 16'h0106);
    rd(4'd2, r);  check("R3 no flag on ignored edge", r, 16'h0000);
    wr(4'd7, 16'h0011); wr(4'd1, 16'h0ABC);
    cap_in[3] = 1'b1; idle(6);
    rd(4'd12, r); check("R3 rising ignored on falling select", r, 16'h0106);
    cap_in[3] = 1'b0; idle(6);
    rd(4'd12, r); check("R3 falling capture", r, 16'h0ABC);
    wr(4'd7, 16'h0019); wr(4'd1, 16'h0DEF);
    cap_in[3] = 1'b1; idle(6);
    rd(4'd12, r); check("R3 either edge rising", r, 16'h0DEF);
    wr(4'd1, 16'h0123);
    cap_in[3] = 1'b0; idle(6);
    rd(4'd12, r); check("R3 either edge falling", r, 16'h0123);

    // R6 PWM
    do_reset();
    wr(4'd10, 16'h0040); wr(4'd5, 16'h0004); wr(4'd1, 16'h0010);
    idle(2);
    check("R6 duty not loaded before wrap", {15'b0, cmp_out[1]}, 16'h0001);
    wr(4'd1, 16'h00FF); wr(4'd0, 16'h0001);
    idle(20);
    check("R6 below duty low", {15'b0, cmp_out[1]}, 16'h0000);
    wr(4'd0, 16'h0000); wr(4'd1, 16'h0150); idle(1);
    check("R6 above duty high", {15'b0, cmp_out[1]}, 16'h0001);
    wr(4'd1, 16'h013F); idle(1);
    check("R6 just below duty", {15'b0, cmp_out[1]}, 16'h0000);
    wr(4'd10, 16'h0010); wr(4'd1, 16'h0120); idle(1);
    check("R6 new duty deferred", {15'b0, cmp_out[1]}, 16'h0000);
    wr(4'd1, 16'h01FF); wr(4'd0, 16'h0001); idle(6);
    wr(4'd0, 16'h0000); wr(4'd1, 16'h0220); idle(1);
    check("R6 new duty after wrap", {15'b0, cmp_out[1]}, 16'h0001);

    // R7 watchdog: kicked, then expired
    do_reset();
    base = wdt_seen;
    wr(4'd8, 16'h0005); wr(4'd13, 16'h0020); wr(4'd0, 16'h0001);
    idle(20); wr(4'd13, 16'h0040);
    idle(40); wr(4'd13, 16'h0060);
    idle(40);
    check("R7 kicked watchdog silent", 16'(wdt_seen - base), 16'h0000);
    wr(4'd0, 16'h0000); wr(4'd1, 16'h0000); wr(4'd13, 16'h0008); wr(4'd0, 16'h0001);
    idle(40);
    check("R7 expired watchdog one pulse", 16'(wdt_seen - base), 16'h0001);
    rd(4'd2, r); check("R7 no flag from watchdog", r, 16'h0000);

    // R7 mode 5 ignored on another channel
    do_reset();
    base = wdt_seen;
    wr(4'd6, 16'h0005); wr(4'd11, 16'h0005); wr(4'd0, 16'h0001);
    idle(40);
    check("R7 ignored on channel 2", 16'(wdt_seen - base), 16'h0000);
    rd(4'd2, r); check("R7 ignored flag", r, 16'h0000);
    check("R7 ignored output", {15'b0, cmp_out[2]}, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule